// File: doc/BRIEF.md
# Serial Port with Shared Data/Handshake Register

This block is an asynchronous serial port reached through three 32-bit registers on a simple word-addressed bus. One register carries both directions of traffic: a write can hand over a byte for transmission, and a read returns the byte received last. Two handshake flags in the same word let software see whether the transmitter is free and whether a received byte is waiting. Software can therefore move bytes with one register and no separate status register.

The registers feed an 8N1 transmit shifter and an 8N1 receive shifter. Each direction has a one-byte holding register. Bit timing comes from a `baud_tick` strobe that a separate rate generator produces at sixteen times the bit rate. The clock register only stores the rate generator's setting and drives it out on `baud_cfg`. The interface-mode field and the two ready-override bits of the control register drive output pins.

Top module: `serlink_port`

## Requirements
- R1: After reset, a read of the data word (offset 0x00) gives bit 8 = 0, bit 9 = 1 and bits 7:0 = 0. The transmit line is high, and the control and clock registers read 0.
- R2: The data word is at byte offset 0x00, the control word at 0x04 and the clock word at 0x08. A read of any other offset returns 0. Read data appears on `bus_rdata` one cycle after the request.
- R3: A write to the data word with bit 9 set, while bit 9 reads 1, sends bits 7:0 as one frame. The frame is a start bit of 0, then eight data bits LSB first, then a stop bit of 1. Each bit lasts 16 `baud_tick` pulses.
- R4: Bit 9 of the data word reads 0 from the accepting write until the stop bit has been fully sent, and then reads 1 again.
- R5: A write with bit 9 set while bit 9 reads 0 is ignored. The frame in progress is unchanged and no further frame follows.
- R6: The receiver detects a falling edge on `ser_rxd`, confirms the start bit 8 ticks later and samples each later bit 16 ticks apart, near mid-bit. When a frame with a high stop bit completes, the byte appears in bits 7:0 of the data word and bit 8 becomes 1.
- R7: A write to the data word with bit 8 = 1 clears bit 8. A write with bit 8 = 0 leaves bit 8 and the held byte unchanged.
- R8: A byte that completes while bit 8 is 1 is dropped, and the held byte is kept.
- R9: A frame whose stop bit samples low is discarded, and bit 8 stays 0.
- R10: The control word holds a mode field in bits 3:2 (1 = DTE, 2 = DCE), a transmit-ready override in bit 7 and a receive-ready override in bit 8. Its other bits read 0. The three fields drive `if_mode`, `tx_rdy_ovr` and `rx_rdy_ovr`.
- R11: The clock word is a 32-bit read/write register whose value drives `baud_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| baud_tick | input | 1 | Strobe at 16x the bit rate |
| ser_rxd | input | 1 | Serial receive line |
| ser_txd | output | 1 | Serial transmit line |
| if_mode | output | 2 | Interface mode field |
| tx_rdy_ovr | output | 1 | Transmit-ready override |
| rx_rdy_ovr | output | 1 | Receive-ready override |
| baud_cfg | output | 32 | Clock register contents |

## Verification
The bench uses the default 8-bit data width and 16x oversampling, and pulses `baud_tick` every second clock, so one bit lasts 32 cycles. With the transmit line looped back to the receive line, all 256 byte values are sent. Each frame is decoded bit by bit at the pins and also read back through the data word, so both shifters are covered for every data pattern. Direct drive of the receive line reaches the bad-stop-bit case. Back-to-back writes and unacknowledged bytes reach the busy-ignore and overrun rules.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  localparam int REG_W = 32;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_CLK  = 2'd2;
  localparam int BIT_RXACK = 8;
  localparam int BIT_TXGO  = 9;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/serlink_tx.sv
module serlink_tx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic          txd
);
  localparam int SUB_W = $clog2(OSR);
  localparam int CNT_W = $clog2(DW + 2);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DW + 1);

  logic [SUB_W-1:0] sub_q;
  logic [CNT_W-1:0] bit_q;
  logic [DW:0]      shf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      sub_q <= '0;
      bit_q <= '0;
      shf_q <= '1;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        txd   <= 1'b0;
        sub_q <= '0;
        bit_q <= '0;
        shf_q <= {1'b1, din};
      end
    end else if (tick) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        if (bit_q == BIT_LAST) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd   <= shf_q[0];
          shf_q <= {1'b1, shf_q[DW:1]};
          bit_q <= bit_q + 1'b1;
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // R1 / R3: line idles high whenever no frame is in flight
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R3: every frame opens with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !txd));
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx
  import serlink_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  output logic          valid,
  output logic [DW-1:0] dout
);
  localparam int SUB_W = $clog2(OSR);
  localparam int CNT_W = $clog2(DW);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DW - 1);

  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_t        st_q;
  logic [SUB_W-1:0] sub_q;
  logic [CNT_W-1:0] bit_q;
  logic [DW-1:0]    shf_q;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      bit_q  <= '0;
      shf_q  <= '0;
      valid  <= 1'b0;
      dout   <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      valid  <= 1'b0;
      if (tick) begin
        unique case (st_q)
          RX_IDLE: begin
            if (!rx_s) begin
              st_q  <= RX_START;
              sub_q <= '0;
            end
          end
          RX_START: begin
            if (sub_q == SUB_MID) begin
              sub_q <= '0;
              bit_q <= '0;
              st_q  <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (sub_q == SUB_LAST) begin
              sub_q <= '0;
              shf_q <= {rx_s, shf_q[DW-1:1]};
              if (bit_q == BIT_LAST) st_q <= RX_STOP;
              else bit_q <= bit_q + 1'b1;
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (sub_q == SUB_LAST) begin
              sub_q <= '0;
              st_q  <= RX_IDLE;
              if (rx_s) begin
                valid <= 1'b1;
                dout  <= shf_q;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  // R6: a completed byte is announced for exactly one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
endmodule

// File: rtl/serlink_port.sv
module serlink_port
  import serlink_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DW     = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              baud_tick,
  input  logic              ser_rxd,
  output logic              ser_txd,
  output logic [1:0]        if_mode,
  output logic              tx_rdy_ovr,
  output logic              rx_rdy_ovr,
  output logic [31:0]       baud_cfg
);
  localparam int WADDR_W = ADDR_W - 2;

  logic [WADDR_W-1:0] waddr;
  logic               hit_data, hit_ctrl, hit_clk;
  logic               wr_data, tx_go, rx_ack;
  logic               tx_busy, tx_ready;
  logic               rx_valid;
  logic [DW-1:0]      rx_byte_new;
  logic [DW-1:0]      rx_hold_q;
  logic               rx_full_q;
  logic [1:0]         mode_q;
  logic               txo_q, rxo_q;
  logic [31:0]        clk_q;
  logic [31:0]        rd_mux;

  assign waddr    = bus_addr[ADDR_W-1:2];
  assign hit_data = (waddr == WADDR_W'(SEL_DATA));
  assign hit_ctrl = (waddr == WADDR_W'(SEL_CTRL));
  assign hit_clk  = (waddr == WADDR_W'(SEL_CLK));
  assign wr_data  = bus_en && bus_we && hit_data;
  assign tx_ready = !tx_busy;
  assign tx_go    = wr_data && bus_wdata[BIT_TXGO] && tx_ready;
  assign rx_ack   = wr_data && bus_wdata[BIT_RXACK];

  serlink_tx #(.DW(DW), .OSR(OSR)) tx_i (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .start (tx_go),
    .din   (bus_wdata[DW-1:0]),
    .busy  (tx_busy),
    .txd   (ser_txd)
  );

  serlink_rx #(.DW(DW), .OSR(OSR)) rx_i (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .rxd   (ser_rxd),
    .valid (rx_valid),
    .dout  (rx_byte_new)
  );

  // receive holding register: ack frees it, a full register drops new bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full_q <= 1'b0;
      rx_hold_q <= '0;
    end else if (rx_valid && (!rx_full_q || rx_ack)) begin
      rx_full_q <= 1'b1;
      rx_hold_q <= rx_byte_new;
    end else if (rx_ack) begin
      rx_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      txo_q  <= 1'b0;
      rxo_q  <= 1'b0;
      clk_q  <= '0;
    end else if (bus_en && bus_we) begin
      if (hit_ctrl) begin
        mode_q <= bus_wdata[3:2];
        txo_q  <= bus_wdata[7];
        rxo_q  <= bus_wdata[8];
      end
      if (hit_clk) clk_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_data) begin
      rd_mux[DW-1:0]    = rx_hold_q;
      rd_mux[BIT_RXACK] = rx_full_q;
      rd_mux[BIT_TXGO]  = tx_ready;
    end else if (hit_ctrl) begin
      rd_mux[3:2] = mode_q;
      rd_mux[7]   = txo_q;
      rd_mux[8]   = rxo_q;
    end else if (hit_clk) begin
      rd_mux = clk_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_mux;
  end

  assign if_mode    = mode_q;
  assign tx_rdy_ovr = txo_q;
  assign rx_rdy_ovr = rxo_q;
  assign baud_cfg   = clk_q;

  // R4: an accepted transmit request makes the transmitter busy next cycle
  a_r4_busy_after_go: assert property (@(posedge clk) disable iff (rst)
    tx_go |=> !tx_ready);
  // R7: acknowledging with no byte arriving empties the holding register
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_ack && !rx_valid) |=> !rx_full_q);
  // R8: a byte arriving while full and unacknowledged leaves the held byte alone
  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
    (rx_full_q && rx_valid && !rx_ack) |=> (rx_full_q && $stable(rx_hold_q)));
endmodule

// File: tb/serlink_port_tb_top.sv
module serlink_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        baud_tick = 1'b0;
  logic        loop_en = 1'b1;
  logic        drv_rxd = 1'b1;
  logic        ser_txd;
  logic        ser_rxd;
  logic [1:0]  if_mode;
  logic        tx_rdy_ovr, rx_rdy_ovr;
  logic [31:0] baud_cfg;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign ser_rxd = loop_en ? ser_txd : drv_rxd;

  serlink_port dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_tick(baud_tick), .ser_rxd(ser_rxd), .ser_txd(ser_txd),
    .if_mode(if_mode), .tx_rdy_ovr(tx_rdy_ovr), .rx_rdy_ovr(rx_rdy_ovr),
    .baud_cfg(baud_cfg)
  );

  // tick on every second cycle: one bit = 32 cycles
  always @(negedge clk) baud_tick <= ~baud_tick;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send a byte, decode it at the pin; ends about 330 cycles after the write
  task automatic send_check(input logic [7:0] b);
    logic [31:0] r;
    logic [9:0] got;
    int bad = 0;
    wr(4'h0, 32'h200 | b);
    idle(15);
    for (int k = 0; k < 10; k++) begin
      got[k] = ser_txd;
      if (k == 4) begin
        rd(4'h0, r);
        chk(r[9] == 1'b0, "R4 busy mid-frame", r[9], 0);
        idle(30);
      end else begin
        idle(32);
      end
    end
    if (got != {1'b1, b, 1'b0}) bad = 1;
    chk(bad == 0, "R3 frame bits", got, {1'b1, b, 1'b0});
  endtask

  task automatic raw_frame(input logic [7:0] b, input logic stopb);
    logic [9:0] f;
    f = {stopb, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      drv_rxd = f[k];
      idle(32);
    end
    drv_rxd = 1'b1;
    idle(40);
  endtask

  initial begin
    logic [31:0] r;
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    rd(4'h0, r);
    chk(r == 32'h200, "R1 data word after reset", r, 32'h200);
    chk(ser_txd == 1'b1, "R1 line idle high", ser_txd, 1);
    rd(4'h4, r);
    chk(r == 0, "R1 control reset", r, 0);
    rd(4'h8, r);
    chk(r == 0, "R1 clock reset", r, 0);
    // R11 clock register
    wr(4'h8, 32'hDEAD_BEEF);
    rd(4'h8, r);
    chk(r == 32'hDEAD_BEEF, "R11 clock readback", r, 32'hDEAD_BEEF);
    chk(baud_cfg == 32'hDEAD_BEEF, "R11 baud_cfg pin", baud_cfg, 32'hDEAD_BEEF);
    // R2 unmapped offset
    rd(4'hC, r);
    chk(r == 0, "R2 unmapped read", r, 0);
    // R10 control fields
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, r);
    chk(r == 32'h18C, "R10 control mask", r, 32'h18C);
    chk(if_mode == 2'd3 && tx_rdy_ovr && rx_rdy_ovr, "R10 control pins",
        {if_mode, tx_rdy_ovr, rx_rdy_ovr}, 4'hF);
    wr(4'h4, 32'h188);
    rd(4'h4, r);
    chk(r == 32'h188 && if_mode == 2'd2, "R10 DCE mode", r, 32'h188);
    wr(4'h4, 32'h004);
    chk(if_mode == 2'd1 && !tx_rdy_ovr && !rx_rdy_ovr, "R10 DTE mode",
        {if_mode, tx_rdy_ovr, rx_rdy_ovr}, 4'h4);
    rd(4'h0, r);
    chk(r[9] == 1'b1, "R2 data word at 0x00", r, 32'h200);
    // R3/R4/R6 loopback sweep over all byte values
    for (int v = 0; v < 256; v++) begin
      send_check(v[7:0]);
      rd(4'h0, r);
      chk(r[9] == 1'b1, "R4 ready after stop", r[9], 1);
      chk(r[8] == 1'b1 && r[7:0] == v[7:0], "R6 loopback byte", r[9:0], 32'h100 | v);
      wr(4'h0, 32'h100);
      rd(4'h0, r);
      chk(r[8] == 1'b0, "R7 ack clears", r[8], 0);
    end
    // R5 write while busy is ignored
    wr(4'h0, 32'h25A);
    wr(4'h0, 32'h2A5);
    rd(4'h0, r);
    chk(r[9] == 1'b0, "R5 still busy", r[9], 0);
    idle(340);
    rd(4'h0, r);
    chk(r[9:0] == 10'h35A, "R5 first byte only", r[9:0], 32'h35A);
    wr(4'h0, 32'h100);
    idle(400);
    rd(4'h0, r);
    chk(r[8] == 1'b0, "R5 no second frame", r[8], 0);
    // R7 writing 0 to bit 8 keeps the byte
    wr(4'h0, 32'h23C);
    idle(340);
    wr(4'h0, 32'h0FF);
    rd(4'h0, r);
    chk(r[9:0] == 10'h33C, "R7 zero write keeps byte", r[9:0], 32'h33C);
    // R8 overrun drops the newer byte
    wr(4'h0, 32'h2C3);
    idle(340);
    rd(4'h0, r);
    chk(r[9:0] == 10'h33C, "R8 held byte kept", r[9:0], 32'h33C);
    wr(4'h0, 32'h100);
    // R9 bad stop bit, then R6 direct drive
    loop_en = 1'b0;
    raw_frame(8'h33, 1'b0);
    rd(4'h0, r);
    chk(r[8] == 1'b0, "R9 framing error dropped", r[8], 0);
    raw_frame(8'h96, 1'b1);
    rd(4'h0, r);
    chk(r[8:0] == 9'h196, "R6 direct frame", r[8:0], 32'h196);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule